// File: doc/BRIEF.md
# Half-Bridge Dead-Time Inserter

This block sits between a bridge decoder and the gate drivers of one half-bridge leg. The decoder supplies two request bits, one for the high-side switch and one for the low-side switch. The block passes them on as gate enables, with one rule: turning a switch off takes effect at once, but turning a switch on waits for a programmable number of clock cycles. So the switch that is leaving always stops conducting before the switch that is arriving starts.

The dead time comes from a register input, `deadCycles`, which the block captures on the clock edge where it first sees a change in either request bit. Every request change restarts the count, so a switch that is waiting stays off until a full dead time has passed with no further change. When the count finishes, the timer goes idle and is armed again for the next change. A value of zero adds no delay. If the decoder asks for both switches at once, neither switch is enabled.

Top module: `hbDeadTime`

## Requirements
- R1: While `rstN` is low, and after reset release with both requests low, `gateHigh` and `gateLow` are both 0.
- R2: If a gate output is 1 and its request is 0 at a rising clock edge, that output is 0 after that edge.
- R3: When a request change (either bit differing from its value at the previous edge) is sampled at edge n with `deadCycles` = D > 0, a newly requested gate stays 0 up to edge n+D-1 and becomes 1 after edge n+D, provided no further change occurs.
- R4: With `deadCycles` = 0, a newly requested gate becomes 1 after the same edge at which the change is sampled.
- R5: A request change sampled while a delay is still running restarts the delay from that edge, and the pending gate stays 0 until D edges after the latest change.
- R6: After a delay completes, the timer re-arms, and the next turn-on waits a full D cycles again.
- R7: When both requests are 1 at an edge, both gate outputs are 0 after that edge.
- R8: `gateHigh` and `gateLow` are never both 1 in the same cycle.
- R9: The delay length is the `deadCycles` value captured at the edge of the latest change. Changing `deadCycles` while the delay is running does not alter the turn-on edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| reqHigh | input | 1 | Requested high-side switch state from the decoder |
| reqLow | input | 1 | Requested low-side switch state from the decoder |
| deadCycles | input | DEAD_W | Turn-on delay in clock cycles, captured at each request change |
| gateHigh | output | 1 | Delayed high-side gate enable |
| gateLow | output | 1 | Delayed low-side gate enable |

## Verification
The outputs are registered. A turn-off is due right after the edge that samples the dropped request. A turn-on is due D edges after the edge that samples the latest request change, or right after that edge when D is zero. The bench changes inputs only on falling edges and compares outputs on the following falling edge. For each edge it counts the edges since the last change and uses the dead time captured at that change, so every expected value is tied to a specific edge. It sweeps the dead time across a range of values in both switching directions. It also checks restart during a delay, re-arming after completion, requests for both switches at once, and a dead-time change during a delay.

// File: rtl/hbDeadPkg.sv
package hbDeadPkg;

  // Strobes from the control to the delay counter.
  typedef struct packed {
    logic load;   // capture the dead time and start a delay
    logic count;  // step a running delay
  } timerCmd_t;

  // Status returned by the delay counter.
  typedef struct packed {
    logic idle;      // no delay running
    logic lastStep;  // delay finishes on this edge
    logic zeroLoad;  // programmed dead time is zero
  } timerStat_t;

endpackage

// File: rtl/hbDeadTimer.sv
module hbDeadTimer
  import hbDeadPkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEAD_W-1:0] deadCycles,
  input  timerCmd_t         cmd,
  output timerStat_t        stat
);

  localparam logic [DEAD_W-1:0] STEP = DEAD_W'(1);

  logic [DEAD_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (cmd.load) begin
      remain <= deadCycles;
    end else if (cmd.count) begin
      remain <= remain - STEP;
    end
  end

  always_comb begin
    stat.idle     = (remain == '0);
    stat.lastStep = (remain == STEP);
    stat.zeroLoad = (deadCycles == '0);
  end

endmodule

// File: rtl/hbDeadCtrl.sv
module hbDeadCtrl
  import hbDeadPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqHigh,
  input  logic       reqLow,
  input  timerStat_t stat,
  output timerCmd_t  cmd,
  output logic       gateHigh,
  output logic       gateLow
);

  logic [1:0] lastReq;
  logic [1:0] safeReq;
  logic       changed;
  logic       release_;

  always_comb begin
    // Conflicting requests enable neither switch.
    safeReq   = {reqHigh & ~reqLow, reqLow & ~reqHigh};
    changed   = ({reqHigh, reqLow} != lastReq);
    cmd.load  = changed;
    cmd.count = ~changed & ~stat.idle;
    // Turn-on allowed when zero delay is loaded, or the delay ends now, or idle.
    release_  = changed ? stat.zeroLoad : (stat.idle | stat.lastStep);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastReq  <= 2'b00;
      gateHigh <= 1'b0;
      gateLow  <= 1'b0;
    end else begin
      lastReq <= {reqHigh, reqLow};
      if (release_) begin
        gateHigh <= safeReq[1];
        gateLow  <= safeReq[0];
      end else begin
        // Turn-offs pass at once; turn-ons hold back.
        gateHigh <= gateHigh & safeReq[1];
        gateLow  <= gateLow & safeReq[0];
      end
    end
  end

endmodule

// File: rtl/hbDeadTime.sv
module hbDeadTime
  import hbDeadPkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqHigh,
  input  logic              reqLow,
  input  logic [DEAD_W-1:0] deadCycles,
  output logic              gateHigh,
  output logic              gateLow
);

  timerCmd_t  cmd;
  timerStat_t stat;

  hbDeadTimer #(.DEAD_W(DEAD_W)) timer (
    .clk       (clk),
    .rstN      (rstN),
    .deadCycles(deadCycles),
    .cmd       (cmd),
    .stat      (stat)
  );

  hbDeadCtrl ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqHigh (reqHigh),
    .reqLow  (reqLow),
    .stat    (stat),
    .cmd     (cmd),
    .gateHigh(gateHigh),
    .gateLow (gateLow)
  );

endmodule

// File: rtl/hbDeadTimeChk.sv
module hbDeadTimeChk (
  input logic clk,
  input logic rstN,
  input logic reqHigh,
  input logic reqLow,
  input logic gateHigh,
  input logic gateLow
);

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHigh && gateLow));

  assert_high_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (gateHigh && !reqHigh) |=> !gateHigh);

  assert_low_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (gateLow && !reqLow) |=> !gateLow);

  assert_high_on_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateHigh) |-> $past(reqHigh && !reqLow));

  assert_low_on_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateLow) |-> $past(reqLow && !reqHigh));

endmodule

bind hbDeadTime hbDeadTimeChk chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqHigh (reqHigh),
  .reqLow  (reqLow),
  .gateHigh(gateHigh),
  .gateLow (gateLow)
);

// File: tb/hbDeadTime_test.sv
`timescale 1ns/1ps
module hbDeadTime_test;

  localparam int DEAD_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqHigh = 1'b0;
  logic              reqLow = 1'b0;
  logic [DEAD_W-1:0] deadCycles = '0;
  logic              gateHigh;
  logic              gateLow;

  int total = 0;
  int bad = 0;

  // Reference state, built from the requirements.
  int edgeN = 0;
  int chgEdge = -1000;
  int dAt = 0;
  logic prevH = 1'b0;
  logic prevL = 1'b0;
  logic expH = 1'b0;
  logic expL = 1'b0;

  always #2 clk = ~clk;

  hbDeadTime #(.DEAD_W(DEAD_W)) uut (
    .clk(clk), .rstN(rstN), .reqHigh(reqHigh), .reqLow(reqLow),
    .deadCycles(deadCycles), .gateHigh(gateHigh), .gateLow(gateLow)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at edge %0d: actual=%b expected=%b", tag, what, edgeN, act, exp);
    end
  endtask

  // One clock: predict at the rising edge, compare at the next falling edge.
  task automatic cyc(input string tag);
    @(posedge clk);
    edgeN++;
    if (reqHigh != prevH || reqLow != prevL) begin
      chgEdge = edgeN;
      dAt = int'(deadCycles);
    end
    prevH = reqHigh;
    prevL = reqLow;
    expH = reqHigh & ~reqLow & ((edgeN - chgEdge) >= dAt);
    expL = reqLow & ~reqHigh & ((edgeN - chgEdge) >= dAt);
    @(negedge clk);
    check(tag, gateHigh, expH, "gateHigh");
    check(tag, gateLow, expL, "gateLow");
    check("R8", gateHigh & gateLow, 1'b0, "overlap");
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", gateHigh, 1'b0, "gateHigh in reset");
    check("R1", gateLow, 1'b0, "gateLow in reset");
    rstN = 1'b1;
    run("R1", 3);

    // R3 / R4: sweep dead time, both directions
    for (int d = 0; d < 10; d++) begin
      deadCycles = DEAD_W'(d);
      reqHigh = 1'b1;
      run(d == 0 ? "R4" : "R3", d + 3);
      reqHigh = 1'b0; reqLow = 1'b1;
      run(d == 0 ? "R2,R4" : "R2,R3", d + 3);
      reqLow = 1'b0;
      run("R2", 3);
    end

    // R5: restart while counting
    deadCycles = DEAD_W'(5);
    reqHigh = 1'b1;
    run("R5", 3);
    reqHigh = 1'b0;
    run("R5", 1);
    reqHigh = 1'b1;
    run("R5", 8);
    reqLow = 1'b1;
    run("R7", 2);
    reqLow = 1'b0;
    run("R5", 8);
    reqHigh = 1'b0;
    run("R2", 2);

    // R6: re-arm after a completed turn-on
    deadCycles = DEAD_W'(3);
    for (int k = 0; k < 3; k++) begin
      reqLow = 1'b1;
      run("R6", 5);
      reqLow = 1'b0;
      run("R6", 2);
    end

    // R7: both requested
    deadCycles = DEAD_W'(0);
    reqHigh = 1'b1; reqLow = 1'b1;
    run("R7", 4);
    reqHigh = 1'b0; reqLow = 1'b0;
    run("R7", 2);

    // R9: dead time changed during a running delay
    deadCycles = DEAD_W'(6);
    reqHigh = 1'b1;
    run("R9", 2);
    deadCycles = DEAD_W'(1);
    run("R9", 7);
    reqHigh = 1'b0;
    run("R9", 2);
    reqLow = 1'b1;
    run("R9", 4);
    reqLow = 1'b0;
    run("R9", 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule